// File: doc/BRIEF.md
# Boot Region Write Lockout Guard

This block protects two boot regions of a byte-addressed flash array: one at the very bottom of the address space and one at the very top. Each region has its own lock flag. The flag is set by a one-cycle lock request, which stands in for the longer unlock-style command sequence decoded elsewhere. Once set, a flag stays set until a dedicated power-on clear. The ordinary reset does not touch it.

The write controller presents each sector program request as a byte address. The guard answers with a grant or a deny one cycle later. A request is denied when its sector lies inside a locked region. The guard also answers whole-chip erase requests, which it refuses while either region is locked. In identification mode, two fixed read addresses return a status byte for each region. The lock state is also visible directly on a port.

Top module: `boot_lock_guard`

## Requirements
- R1: While `rst_n` is low and for the first cycle after it rises, `wr_grant`, `wr_deny`, `erase_grant`, `erase_deny`, `id_hit` and `id_data` are all 0. A pulse of `rst_n` leaves `lock_state` unchanged.
- R2: Driving `por_n` low clears both lock flags, so `lock_state` reads 2'b00.
- R3: A high `lock_req[0]` at a clock edge sets `lock_state[0]` (the lower region) from that edge on. `lock_req[1]` does the same for `lock_state[1]` (the upper region). Each flag is independent of the other, and a set flag stays set until `por_n`.
- R4: Each cycle with `wr_req` high yields, one cycle later, exactly one of `wr_grant` or `wr_deny` for one cycle. A cycle without `wr_req` yields neither.
- R5: With `lock_state[0]` set, a write whose address lies in 0x00000–0x01FFF is denied. With `lock_state[1]` set, a write in 0x1E000–0x1FFFF is denied. Both regions are whole 128-byte sectors, so every byte of the target sector is covered.
- R6: A write to an address in no locked region is granted. This includes addresses just outside a locked region and addresses inside a region that is not locked.
- R7: An `erase_req` yields `erase_grant` one cycle later when both flags are clear. It yields `erase_deny` one cycle later when either flag is set.
- R8: With `id_mode` high, reading `rd_addr` 0x00002 gives `id_hit`=1 one cycle later and `id_data` 0xFE if the lower region is unlocked or 0xFF if it is locked. Reading 0x1FFF2 reports the upper region in the same way.
- R9: Any other `rd_addr`, or `id_mode` low, gives `id_hit`=0 and `id_data`=0x00 one cycle later.
- R10: A write, erase or identification request made in the same cycle as a `lock_req` is judged on the flags as they stood before that edge. The new lock applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the response registers; lock flags untouched |
| por_n | input | 1 | Asynchronous active-low power-on clear of the lock flags |
| lock_req | input | 2 | One-cycle lock pulse; bit 0 lower region, bit 1 upper region |
| wr_req | input | 1 | Sector program request valid |
| wr_addr | input | 17 | Byte address inside the target sector |
| erase_req | input | 1 | Whole-chip erase request |
| id_mode | input | 1 | Identification mode active |
| rd_addr | input | 17 | Read address in identification mode |
| wr_grant | output | 1 | Program allowed (one cycle after request) |
| wr_deny | output | 1 | Program refused (one cycle after request) |
| erase_grant | output | 1 | Chip erase allowed |
| erase_deny | output | 1 | Chip erase refused |
| id_hit | output | 1 | Identification read matched a status address |
| id_data | output | 8 | Status byte for the matched region, else 0x00 |
| lock_state | output | 2 | Current lock flags; bit 0 lower, bit 1 upper |

## Verification
Every response register, meaning the grant, deny and identification outputs, settles one cycle after the request that caused it. The lock flags settle at the same edge as their lock pulse. The bench therefore drives each stimulus on a falling edge and reads the result on the next falling edge, so exactly one rising edge lies between the two. A separate test places a lock pulse and requests on the same edge to confirm that the verdict uses the flags from before that edge. It then checks that the following request sees the new lock.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;

   localparam int unsigned NUM_REGIONS = 2;

   typedef enum logic [0:0] {
      RGN_LOW  = 1'b0,
      RGN_HIGH = 1'b1
   } region_e;

   localparam logic [7:0] STAT_OPEN   = 8'hFE;
   localparam logic [7:0] STAT_LOCKED = 8'hFF;

   typedef struct packed {
      logic grant;
      logic deny;
   } verdict_t;

   function automatic verdict_t judge(input logic req, input logic blocked);
      verdict_t v;
      v.grant = req & ~blocked;
      v.deny  = req &  blocked;
      return v;
   endfunction

endpackage

// File: rtl/blg_region_decode.sv
module blg_region_decode
   import boot_lock_pkg::*;
#(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned REGION_BYTES = 8192
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic [NUM_REGIONS-1:0] hit
);
   localparam longint unsigned MEM_BYTES = 64'd1 << ADDR_W;
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(REGION_BYTES);

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
      localparam logic [ADDR_W-1:0] BASE =
         (i == int'(RGN_LOW)) ? '0 : ADDR_W'(MEM_BYTES - REGION_BYTES);
      logic [ADDR_W-1:0] offset;
      // offset wraps below BASE, so one compare bounds both ends
      assign offset = addr - BASE;
      assign hit[i] = (offset < SPAN);
   end

endmodule

// File: rtl/blg_lock_flags.sv
module blg_lock_flags
   import boot_lock_pkg::*;
(
   input  logic                   clk,
   input  logic                   por_n,
   input  logic [NUM_REGIONS-1:0] set_req,
   output logic [NUM_REGIONS-1:0] flags
);
   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            flags[i] <= 1'b0;
         else if (set_req[i])
            flags[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/blg_id_status.sv
module blg_id_status
   import boot_lock_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter logic [ADDR_W-1:0] LO_ID_ADDR = 17'h00002,
   parameter logic [ADDR_W-1:0] HI_ID_ADDR = 17'h1FFF2
) (
   input  logic                   id_mode,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic [NUM_REGIONS-1:0] flags,
   output logic                   hit,
   output logic [7:0]             data
);
   logic [NUM_REGIONS-1:0] sel;

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
      localparam logic [ADDR_W-1:0] ID_ADDR =
         (i == int'(RGN_LOW)) ? LO_ID_ADDR : HI_ID_ADDR;
      assign sel[i] = id_mode & (rd_addr == ID_ADDR);
   end

   always_comb begin
      hit  = |sel;
      data = 8'h00;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (sel[i])
            data = flags[i] ? STAT_LOCKED : STAT_OPEN;
      end
   end

endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
   import boot_lock_pkg::*;
#(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned REGION_BYTES = 8192,
   parameter int unsigned SECTOR_BYTES = 128,
   parameter logic [ADDR_W-1:0] LO_ID_ADDR = 17'h00002,
   parameter logic [ADDR_W-1:0] HI_ID_ADDR = 17'h1FFF2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [1:0]        lock_req,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              erase_req,
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_grant,
   output logic              wr_deny,
   output logic              erase_grant,
   output logic              erase_deny,
   output logic              id_hit,
   output logic [7:0]        id_data,
   output logic [1:0]        lock_state
);
   localparam longint unsigned MEM_BYTES = 64'd1 << ADDR_W;

   // elaboration-time parameter checks
   if (REGION_BYTES == 0 || (REGION_BYTES % SECTOR_BYTES) != 0) begin : g_bad_align
      $error("REGION_BYTES must be a nonzero multiple of SECTOR_BYTES");
   end
   if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_sector
      $error("SECTOR_BYTES must be a power of two");
   end
   if (2 * longint'(REGION_BYTES) > MEM_BYTES) begin : g_bad_fit
      $error("both regions must fit in the address space");
   end
   if (longint'(LO_ID_ADDR) >= REGION_BYTES) begin : g_bad_lo_id
      $error("LO_ID_ADDR must lie in the lower region");
   end
   if (longint'(HI_ID_ADDR) < MEM_BYTES - REGION_BYTES) begin : g_bad_hi_id
      $error("HI_ID_ADDR must lie in the upper region");
   end

   logic [NUM_REGIONS-1:0] flags;
   logic [NUM_REGIONS-1:0] wr_hit;
   logic                   id_sel;
   logic [7:0]             id_byte;
   verdict_t               wr_v, er_v;

   blg_lock_flags u_flags (
      .clk     (clk),
      .por_n   (por_n),
      .set_req (lock_req),
      .flags   (flags)
   );

   blg_region_decode #(
      .ADDR_W       (ADDR_W),
      .REGION_BYTES (REGION_BYTES)
   ) u_decode (
      .addr (wr_addr),
      .hit  (wr_hit)
   );

   blg_id_status #(
      .ADDR_W     (ADDR_W),
      .LO_ID_ADDR (LO_ID_ADDR),
      .HI_ID_ADDR (HI_ID_ADDR)
   ) u_status (
      .id_mode (id_mode),
      .rd_addr (rd_addr),
      .flags   (flags),
      .hit     (id_sel),
      .data    (id_byte)
   );

   assign wr_v = judge(wr_req,    |(wr_hit & flags));
   assign er_v = judge(erase_req, |flags);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_grant    <= 1'b0;
         wr_deny     <= 1'b0;
         erase_grant <= 1'b0;
         erase_deny  <= 1'b0;
         id_hit      <= 1'b0;
         id_data     <= 8'h00;
      end else begin
         wr_grant    <= wr_v.grant;
         wr_deny     <= wr_v.deny;
         erase_grant <= er_v.grant;
         erase_deny  <= er_v.deny;
         id_hit      <= id_sel;
         id_data     <= id_byte;
      end
   end

   assign lock_state = flags;

endmodule

// File: rtl/boot_lock_guard_chk.sv
module boot_lock_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       por_n,
   input logic [1:0] lock_req,
   input logic       wr_req,
   input logic       erase_req,
   input logic       wr_grant,
   input logic       wr_deny,
   input logic       erase_grant,
   input logic       erase_deny,
   input logic       id_hit,
   input logic [7:0] id_data,
   input logic [1:0] lock_state
);
   // R4
   wr_verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $onehot0({wr_grant, wr_deny}));

   // R4
   wr_answer_due_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      wr_req |=> (wr_grant || wr_deny));

   // R4
   wr_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !wr_req |=> !(wr_grant || wr_deny));

   // R3
   lo_lock_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_req[0] |=> lock_state[0]);

   // R3
   hi_lock_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_req[1] |=> lock_state[1]);

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (lock_state == 2'b11) |=> (lock_state == 2'b11));

   // R7
   erase_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (erase_req && (lock_state != 2'b00)) |=> (erase_deny && !erase_grant));

   // R8
   id_byte_form_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      id_hit |-> (id_data[7:1] == 7'h7F));

   // R9
   id_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !id_hit |-> (id_data == 8'h00));

endmodule

bind boot_lock_guard boot_lock_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .por_n       (por_n),
   .lock_req    (lock_req),
   .wr_req      (wr_req),
   .erase_req   (erase_req),
   .wr_grant    (wr_grant),
   .wr_deny     (wr_deny),
   .erase_grant (erase_grant),
   .erase_deny  (erase_deny),
   .id_hit      (id_hit),
   .id_data     (id_data),
   .lock_state  (lock_state)
);

// File: tb/boot_lock_guard_test.sv
`timescale 1ns/100ps
module boot_lock_guard_test;
   logic        clk = 1'b0;
   logic        rst_n, por_n;
   logic [1:0]  lock_req;
   logic        wr_req, erase_req, id_mode;
   logic [16:0] wr_addr, rd_addr;
   logic        wr_grant, wr_deny, erase_grant, erase_deny, id_hit;
   logic [7:0]  id_data;
   logic [1:0]  lock_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit mlo = 1'b0, mhi = 1'b0;

   always #2.5 clk = ~clk;

   boot_lock_guard uut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .lock_req(lock_req),
      .wr_req(wr_req), .wr_addr(wr_addr), .erase_req(erase_req),
      .id_mode(id_mode), .rd_addr(rd_addr), .wr_grant(wr_grant),
      .wr_deny(wr_deny), .erase_grant(erase_grant), .erase_deny(erase_deny),
      .id_hit(id_hit), .id_data(id_data), .lock_state(lock_state)
   );

   // kind in [18:17]: 0 write, 1 erase, 2 identification read
   localparam logic [18:0] VEC [12] = '{
      {2'd0, 17'h00000}, {2'd0, 17'h01F80}, {2'd0, 17'h01FFF},
      {2'd0, 17'h02000}, {2'd0, 17'h10000}, {2'd0, 17'h1DFFF},
      {2'd0, 17'h1E000}, {2'd0, 17'h1FFFF}, {2'd1, 17'h00000},
      {2'd2, 17'h00002}, {2'd2, 17'h1FFF2}, {2'd2, 17'h00003}
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      lock_req = 2'b00; wr_req = 1'b0; erase_req = 1'b0; id_mode = 1'b0;
      wr_addr = '0; rd_addr = '0;
   endtask

   task automatic power_clear();
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      mlo = 1'b0; mhi = 1'b0;
      check("R2 lock_state after por", 32'(lock_state), 32'd0);
   endtask

   task automatic do_lock(logic [1:0] which);
      @(negedge clk); lock_req = which;
      @(negedge clk); lock_req = 2'b00;
      mlo |= which[0]; mhi |= which[1];
      check("R3 lock_state after lock", 32'(lock_state), 32'({mhi, mlo}));
   endtask

   task automatic walk();
      for (int i = 0; i < 12; i++) begin
         logic [1:0]  k = VEC[i][18:17];
         logic [16:0] a = VEC[i][16:0];
         bit in_lo = (a < 17'h02000);
         bit in_hi = (a >= 17'h1E000);
         bit blk   = (in_lo && mlo) || (in_hi && mhi);
         @(negedge clk);
         if (k == 2'd0) begin wr_req = 1'b1; wr_addr = a; end
         else if (k == 2'd1) erase_req = 1'b1;
         else begin id_mode = 1'b1; rd_addr = a; end
         @(negedge clk);
         idle();
         if (k == 2'd0) begin
            if (blk) check("R5 write denied in locked region", 32'({wr_grant, wr_deny}), 32'b01);
            else     check("R6 write granted outside lock",   32'({wr_grant, wr_deny}), 32'b10);
         end else if (k == 2'd1) begin
            check("R7 erase verdict", 32'({erase_grant, erase_deny}),
                  (mlo || mhi) ? 32'b01 : 32'b10);
         end else if (a == 17'h00002) begin
            check("R8 lower id status", 32'({id_hit, id_data}), mlo ? 32'h1FF : 32'h1FE);
         end else if (a == 17'h1FFF2) begin
            check("R8 upper id status", 32'({id_hit, id_data}), mhi ? 32'h1FF : 32'h1FE);
         end else begin
            check("R9 non-status id read", 32'({id_hit, id_data}), 32'h000);
         end
      end
   endtask

   initial begin : wd
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0; por_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 outputs in reset",
            32'({wr_grant, wr_deny, erase_grant, erase_deny, id_hit, id_data}), 32'd0);
      check("R2 lock_state at power-on", 32'(lock_state), 32'd0);
      rst_n = 1'b1; por_n = 1'b1;
      @(negedge clk);
      check("R1 outputs after reset",
            32'({wr_grant, wr_deny, erase_grant, erase_deny, id_hit, id_data}), 32'd0);

      walk();                    // nothing locked
      do_lock(2'b01); walk();    // lower only
      power_clear();
      do_lock(2'b10); walk();    // upper only
      do_lock(2'b01); walk();    // both

      // R1 reset pulse keeps locks
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 outputs during reset pulse", 32'({wr_grant, wr_deny, id_hit}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 lock_state survives rst_n", 32'(lock_state), 32'b11);

      // R9 id_mode low at a status address
      @(negedge clk); rd_addr = 17'h00002; id_mode = 1'b0;
      @(negedge clk); idle();
      check("R9 id_mode low", 32'({id_hit, id_data}), 32'h000);

      // R4 no request gives no verdict
      @(negedge clk);
      check("R4 idle cycle no verdict", 32'({wr_grant, wr_deny}), 32'b00);

      // R10 same-edge lock and requests see old flags
      power_clear();
      @(negedge clk);
      lock_req = 2'b01; wr_req = 1'b1; wr_addr = 17'h00100;
      erase_req = 1'b1; id_mode = 1'b1; rd_addr = 17'h00002;
      @(negedge clk); idle();
      mlo = 1'b1;
      check("R10 same-edge write granted", 32'({wr_grant, wr_deny}), 32'b10);
      check("R10 same-edge erase granted", 32'({erase_grant, erase_deny}), 32'b10);
      check("R10 same-edge id reads open", 32'({id_hit, id_data}), 32'h1FE);
      @(negedge clk); wr_req = 1'b1; wr_addr = 17'h00100;
      @(negedge clk); idle();
      check("R10 next write denied", 32'({wr_grant, wr_deny}), 32'b01);
      check("R3 upper stays clear", 32'(lock_state), 32'b01);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule